// File: doc/BRIEF.md
# T1 Pulse Density Monitor and Enforcer

This block watches a serial T1 bit stream, one bit per strobe, and checks it against the ones-density rules that a T1 line must obey. There are two rules. A run of zeros may not grow past fifteen. For every N from 1 to 23, every stretch of 8·(N+1) consecutive bits must carry at least N ones. When a bit breaks either rule, a sticky violation flag is raised. The flag stays up until software-side logic pulses a clear input.

The same block serves both directions of a line card: one instance sits on the transmit path and one on the receive path. In enforce mode the block rewrites the stream it passes on. A zero is replaced by a one whenever sending that zero would break a rule, so the outgoing stream always complies. Enforce mode is meant for raw or AMI lines. It should be left off on B8ZS lines, because the line code already guarantees the density. Framing and line coding lie outside the block.

Top module: `pulse_density_guard`

## Requirements
- R1: A bit flags a violation when it is a zero that ends a run of 16 or more consecutive zeros sent since reset.
- R2: For each N from 1 to 23, a bit flags a violation when the 8·(N+1) sent bits ending with it hold fewer than N ones.
- R3: A window of length 8·(N+1) is judged only once at least that many bits have been strobed since reset; shorter histories never flag.
- R4: The violation flag is sticky. A `clearFlag` pulse drops it at the next clock edge, unless a failing bit is strobed in that same cycle, in which case the flag stays set.
- R5: With `enforceEn` high, a zero on `dataIn` is sent as a one exactly when sending the zero would break R1, or would leave some window of R2 below its minimum. For this decision, positions before reset count as ones.
- R6: With `enforceEn` low, `dataOut` equals the `dataIn` of the strobe cycle, from the next clock edge on.
- R7: A one on `dataIn` is always sent as a one, in both modes.
- R8: While `bitEn` is low, `dataOut`, `violation` and the bit history do not change, whatever `dataIn` does.
- R9: Reset drives `dataOut` and `violation` to 0 and restarts the zero-run and window history.
- R10: The rules are judged on the bit actually sent. A stream kept compliant by enforce mode therefore never raises the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Strobe: one stream bit is taken on this cycle |
| dataIn | input | 1 | Incoming stream bit |
| enforceEn | input | 1 | 1 = rewrite zeros when needed to keep compliance |
| clearFlag | input | 1 | Pulse to clear the sticky violation flag |
| dataOut | output | 1 | Bit sent, registered on the strobe edge |
| violation | output | 1 | Sticky density violation flag |

## Verification
An all-ones preload followed by exactly fifteen zeros and then a sixteenth zero separates the zero-run limit from the window rules. A one-in-sixteen pattern passes the run limit but fails the 24-bit window on a known bit. Streams with one one every 8 and every 9 bits separate a stream that exactly meets every window from one that breaks only the longer windows. A fifteen-zero start after reset shows that partially filled windows are not judged. Enforce mode is driven with all zeros, all ones and a sparse pseudo-random stream, and every bit sent and every flag value is compared against a model that counts each window afresh.

// File: rtl/pdm_pkg.sv
`timescale 1ns/1ps
package pdm_pkg;
  // Per-bit command from the control into the history datapath
  typedef struct packed {
    logic shift;    // take one bit into the history
    logic sentBit;  // the bit actually driven onto the output
  } pdmStrobe_t;
endpackage

// File: rtl/pdm_datapath.sv
`timescale 1ns/1ps
module pdm_datapath
  import pdm_pkg::*;
#(
  parameter int WIN_STEP     = 8,
  parameter int MAX_ONES     = 23,
  parameter int MAX_ZERO_RUN = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pdmStrobe_t strobe,
  output logic       zeroFailRaw,
  output logic       zeroFailJudged,
  output logic       oneFailJudged
);
  localparam int HIST_LEN = WIN_STEP * (MAX_ONES + 1);
  localparam int CNT_W    = $clog2(HIST_LEN + 2);
  localparam int RUN_W    = $clog2(MAX_ZERO_RUN + 2);

  logic [HIST_LEN-1:0] hist;     // hist[0] is the newest sent bit
  logic [CNT_W-1:0]    fillCnt;
  logic [RUN_W-1:0]    zeroRun;
  logic [MAX_ONES-1:0] winZeroLow, winOneLow, winFull;
  logic                runFail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '1;
      fillCnt <= '0;
      zeroRun <= '0;
    end else if (strobe.shift) begin
      hist <= {hist[HIST_LEN-2:0], strobe.sentBit};
      if (fillCnt != CNT_W'(HIST_LEN)) fillCnt <= fillCnt + 1'b1;
      if (strobe.sentBit) zeroRun <= '0;
      else if (zeroRun != RUN_W'(MAX_ZERO_RUN + 1)) zeroRun <= zeroRun + 1'b1;
    end
  end

  assign runFail = (zeroRun >= RUN_W'(MAX_ZERO_RUN));

  for (genvar gi = 0; gi < MAX_ONES; gi++) begin : g_win
    localparam int NEED = gi + 1;
    localparam int LEN  = WIN_STEP * (NEED + 1);
    logic [CNT_W-1:0] onesCnt, cntIfZero, cntIfOne;
    logic             leaving;

    assign leaving       = hist[LEN-1];
    assign cntIfZero     = onesCnt - CNT_W'(leaving);
    assign cntIfOne      = cntIfZero + CNT_W'(1);
    assign winZeroLow[gi] = cntIfZero < CNT_W'(NEED);
    assign winOneLow[gi]  = cntIfOne < CNT_W'(NEED);
    assign winFull[gi]    = fillCnt >= CNT_W'(LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) onesCnt <= CNT_W'(LEN);
      else if (strobe.shift) onesCnt <= strobe.sentBit ? cntIfOne : cntIfZero;
    end
  end

  assign zeroFailRaw    = runFail | (|winZeroLow);
  assign zeroFailJudged = runFail | (|(winZeroLow & winFull));
  assign oneFailJudged  = |(winOneLow & winFull);
endmodule

// File: rtl/pdm_control.sv
`timescale 1ns/1ps
module pdm_control
  import pdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bitEn,
  input  logic       dataIn,
  input  logic       enforceEn,
  input  logic       clearFlag,
  input  logic       zeroFailRaw,
  input  logic       zeroFailJudged,
  input  logic       oneFailJudged,
  output pdmStrobe_t strobe,
  output logic       dataOut,
  output logic       violation
);
  logic forceOne, sentBit, failNow;

  assign forceOne = enforceEn & ~dataIn & zeroFailRaw;
  assign sentBit  = dataIn | forceOne;
  assign failNow  = bitEn & (sentBit ? oneFailJudged : zeroFailJudged);

  assign strobe.shift   = bitEn;
  assign strobe.sentBit = sentBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut   <= 1'b0;
      violation <= 1'b0;
    end else begin
      if (bitEn) dataOut <= sentBit;
      violation <= (violation & ~clearFlag) | failNow;
    end
  end
endmodule

// File: rtl/pulse_density_guard.sv
`timescale 1ns/1ps
module pulse_density_guard
  import pdm_pkg::*;
#(
  parameter int WIN_STEP     = 8,
  parameter int MAX_ONES     = 23,
  parameter int MAX_ZERO_RUN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bitEn,
  input  logic dataIn,
  input  logic enforceEn,
  input  logic clearFlag,
  output logic dataOut,
  output logic violation
);
  pdmStrobe_t strobe;
  logic zeroFailRaw, zeroFailJudged, oneFailJudged;

  pdm_datapath #(
    .WIN_STEP(WIN_STEP), .MAX_ONES(MAX_ONES), .MAX_ZERO_RUN(MAX_ZERO_RUN)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .zeroFailRaw(zeroFailRaw), .zeroFailJudged(zeroFailJudged),
    .oneFailJudged(oneFailJudged)
  );

  pdm_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .dataIn(dataIn),
    .enforceEn(enforceEn), .clearFlag(clearFlag),
    .zeroFailRaw(zeroFailRaw), .zeroFailJudged(zeroFailJudged),
    .oneFailJudged(oneFailJudged),
    .strobe(strobe), .dataOut(dataOut), .violation(violation)
  );
endmodule

// File: rtl/pdm_checker.sv
`timescale 1ns/1ps
module pdm_checker (
  input logic clk,
  input logic rst_n,
  input logic bitEn,
  input logic dataIn,
  input logic enforceEn,
  input logic clearFlag,
  input logic dataOut,
  input logic violation
);
  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    bitEn && !enforceEn |=> dataOut == $past(dataIn));

  a_r7_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
    bitEn && dataIn |=> dataOut);

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bitEn |=> $stable(dataOut));

  a_r8_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !bitEn && !violation |=> !violation);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    violation && !clearFlag |=> violation);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clearFlag && !bitEn |=> !violation);
endmodule

bind pulse_density_guard pdm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .dataIn(dataIn),
  .enforceEn(enforceEn), .clearFlag(clearFlag),
  .dataOut(dataOut), .violation(violation)
);

// File: tb/pulse_density_guard_tb.sv
`timescale 1ns/1ps
module pulse_density_guard_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bitEn = 1'b0, dataIn = 1'b0, enforceEn = 1'b0, clearFlag = 1'b0;
  logic dataOut, violation;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pulse_density_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .dataIn(dataIn),
    .enforceEn(enforceEn), .clearFlag(clearFlag),
    .dataOut(dataOut), .violation(violation)
  );

  // reference model: sent bits since reset, windows recounted from scratch
  bit sentArr [0:4095];
  int nSent = 0;
  bit mFlag = 0, mOut = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit histBit(int back);
    if (nSent - back < 0) return 1'b1;
    return sentArr[nSent - back];
  endfunction

  function automatic bit modelFail(bit b, bit judged);
    bit f = 0;
    if (!b) begin
      bit allZero = 1;
      for (int k = 1; k <= 15; k++) if (histBit(k)) allZero = 0;
      if (allZero) f = 1;
    end
    for (int n = 1; n <= 23; n++) begin
      int len = 8 * (n + 1);
      int ones = int'(b);
      if (!(judged && (nSent + 1 < len))) begin
        for (int k = 1; k < len; k++) ones += int'(histBit(k));
        if (ones < n) f = 1;
      end
    end
    return f;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; bitEn = 0; dataIn = 0; enforceEn = 0; clearFlag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    nSent = 0; mFlag = 0; mOut = 0;
  endtask

  // strobe one bit; called at a negedge, returns at the next negedge
  task automatic sendBit(bit d, bit en, bit clr, string flagTag);
    bit s;
    s = d | (en & ~d & modelFail(1'b0, 1'b0));
    mFlag = (mFlag & ~clr) | modelFail(s, 1'b1);
    sentArr[nSent] = s; nSent++; mOut = s;
    bitEn = 1; dataIn = d; enforceEn = en; clearFlag = clr;
    @(negedge clk);
    bitEn = 0; clearFlag = 0;
    chk(en ? "R5 dataOut" : "R6 dataOut", int'(dataOut), int'(s));
    chk(flagTag, int'(violation), int'(mFlag));
  endtask

  task automatic sendRun(bit d, int cnt, bit en, string flagTag);
    for (int i = 0; i < cnt; i++) sendBit(d, en, 1'b0, flagTag);
  endtask

  task automatic t_reset();
    doReset();
    chk("R9 dataOut after reset", int'(dataOut), 0);
    chk("R9 violation after reset", int'(violation), 0);
  endtask

  task automatic t_zero_run();
    doReset();
    sendRun(1'b1, 200, 1'b0, "R1 flag");
    sendRun(1'b0, 15, 1'b0, "R1 flag");
    chk("R1 fifteen zeros allowed", int'(violation), 0);
    sendBit(1'b0, 1'b0, 1'b0, "R1 flag");
    chk("R1 sixteenth zero flags", int'(violation), 1);
  endtask

  task automatic t_window();
    doReset();
    sendRun(1'b1, 200, 1'b0, "R2 flag");
    for (int i = 0; i < 24; i++) sendBit((i % 16) == 0, 1'b0, 1'b0, "R2 flag");
    chk("R2 24-bit window still met", int'(violation), 0);
    sendBit(1'b0, 1'b0, 1'b0, "R2 flag");
    chk("R2 24-bit window short of 2 ones", int'(violation), 1);
    // one in eight meets every window exactly
    doReset();
    for (int i = 0; i < 400; i++) sendBit((i % 8) == 7, 1'b0, 1'b0, "R2 flag");
    chk("R2 one-in-8 compliant", int'(violation), 0);
    // one in nine breaks the long windows only
    doReset();
    for (int i = 0; i < 400; i++) sendBit((i % 9) == 8, 1'b0, 1'b0, "R2 flag");
    chk("R2 one-in-9 breaks long window", int'(violation), 1);
  endtask

  task automatic t_fill();
    doReset();
    sendRun(1'b0, 15, 1'b0, "R3 flag");
    sendBit(1'b1, 1'b0, 1'b0, "R3 flag");
    chk("R3 partial 24-bit window not judged", int'(violation), 0);
    sendRun(1'b1, 200, 1'b0, "R3 flag");
    chk("R3 no flag after fill", int'(violation), 0);
  endtask

  task automatic t_clear_hold();
    doReset();
    sendRun(1'b0, 16, 1'b0, "R4 flag");
    sendRun(1'b1, 20, 1'b0, "R4 flag");
    chk("R4 flag sticky", int'(violation), 1);
    clearFlag = 1;
    @(negedge clk);
    clearFlag = 0; mFlag = 0;
    chk("R4 clear drops flag", int'(violation), 0);
    // R8: idle cycles with toggling data change nothing
    for (int i = 0; i < 30; i++) begin
      dataIn = ~dataIn;
      @(negedge clk);
      chk("R8 dataOut held", int'(dataOut), int'(mOut));
      chk("R8 violation held", int'(violation), 0);
    end
    sendRun(1'b0, 15, 1'b0, "R8 flag");
    chk("R8 history untouched by idle", int'(violation), 0);
    sendBit(1'b0, 1'b0, 1'b1, "R4 flag");
    chk("R4 fail wins over clear", int'(violation), 1);
  endtask

  task automatic t_enforce();
    doReset();
    sendRun(1'b0, 600, 1'b1, "R10 flag");
    chk("R10 enforced zeros never flag", int'(violation), 0);
    sendRun(1'b1, 50, 1'b1, "R7 flag");
    chk("R7 ones passed", int'(dataOut), 1);
    for (int i = 0; i < 800; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendBit(lfsr[0] & lfsr[3] & lfsr[7], 1'b1, 1'b0, "R5 flag");
    end
    chk("R5 sparse stream enforced clean", int'(violation), 0);
    for (int i = 0; i < 800; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendBit(lfsr[0] & lfsr[3] & lfsr[7], 1'b0, 1'b0, "R6 flag");
    end
    chk("R6 sparse stream unenforced flags", int'(violation), 1);
  endtask

  initial begin
    t_reset();
    t_zero_run();
    t_window();
    t_fill();
    t_clear_hold();
    t_enforce();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule